// File: doc/BRIEF.md
# Timer Event Flag Bank with Read-Armed Clearing

This block keeps the event flags and the interrupt enables of one timer channel and turns them into an interrupt request. The counter and the compare logic beside it send single-cycle set pulses for four compare-match events (A to D), counter overflow and counter underflow. Software reaches two 8-bit registers over a simple synchronous bus with an address, a read strobe, a write strobe, write data and read data. The status register sits at address 0 and the enable register at address 1.

Software cannot simply clear a flag. Each status bit has an arm latch. Every read of the status register loads each arm latch with the value that the read returned for that bit. Every write to the status register clears all arm latches, whatever the data. A status write clears a flag only where the data bit is zero and the arm latch is set. A flag raised by hardware after the last read therefore survives a clearing write, so no event is lost between the read and the write.

The request is a level: the OR of each compare-match flag ANDed with its enable, and the overflow flag ANDed with its enable. A one-cycle pulse comes with every rising edge of that level.

Top module: `evt_flag_bank`

## Requirements
- R1: The status register is at address 0. Its bit i (i = 0..3) is compare-match flag A, B, C, D in that order, bit 4 is overflow and bit 5 is underflow; bits 6 and 7 read 0. While `bus_rd` is high, `bus_rdata` shows the addressed register in the same cycle. An address other than 0 or 1 reads 0, and `bus_rdata` is 0 while `bus_rd` is low.
- R2: The enable register is at address 1. Bit i (i = 0..3) enables compare-match A..D and bit 4 enables overflow. A write loads bits 0..4 at the clock edge; bits 5..7 are dropped on write and read 0.
- R3: A set pulse on `evt_cmp[i]`, `evt_ovf` or `evt_udf` makes the matching status bit read 1 from the next cycle on. A flag never sets without its pulse.
- R4: Writing 1 to a status bit leaves that bit unchanged.
- R5: Writing 0 to a status bit does not clear it if the last status read returned 0 for that bit. This also holds when hardware set the flag after that read.
- R6: Writing 0 to a status bit clears it at that clock edge if the last status read returned 1 for that bit and no status write came between. Any status write disarms every bit.
- R7: If a set pulse and a clearing write hit the same bit in the same cycle, the bit stays 1.
- R8: `irq_level` is the OR of (status[i] AND enable[i]) for i = 0..4. The underflow flag never drives it.
- R9: `irq_pulse` is high for exactly one cycle, in the first cycle in which `irq_level` is high after being low. This includes a rise caused by an enable write.
- R10: After reset, all flags, enables and arm latches are 0, and `irq_level` and `irq_pulse` are 0.
- R11: A single status write may clear a masked flag together with a set, armed, enabled flag. The request then falls and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; also arms the status bits on a status read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| evt_cmp | input | 4 | Compare-match set pulses A..D |
| evt_ovf | input | 1 | Overflow set pulse |
| evt_udf | input | 1 | Underflow set pulse |
| irq_level | output | 1 | OR of the enabled flags |
| irq_pulse | output | 1 | One-cycle pulse on each rise of `irq_level` |

## Verification
A wrong arm latch shows only on the next status write. Either a flag that should survive reads back 0, or a flag that should clear stays 1, so each check reads the register right after the write. A wrong flag or enable shows on `irq_level` in the cycle after the bad edge. A stuck level register shows on `irq_pulse` in the same cycle, as a missing pulse or an extra one, so level and pulse are sampled after every bus cycle. The event sequences place hardware sets between a read and a write, and also in the same cycle as a write, because that is where a plain write-zero-to-clear register would lose an event.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;

   // register selected by a bus cycle
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_EN   = 2'd2
   } reg_sel_e;

   // default geometry
   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_N_CMP  = 4;
   localparam int unsigned DEF_ADDR_W = 2;

   function automatic reg_sel_e decode_sel(input logic [DEF_ADDR_W-1:0] addr,
                                           input logic [DEF_ADDR_W-1:0] stat_a,
                                           input logic [DEF_ADDR_W-1:0] en_a);
      if (addr == stat_a)    return SEL_STAT;
      else if (addr == en_a) return SEL_EN;
      else                   return SEL_NONE;
   endfunction

endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic rd_stat,
   input  logic wr_stat,
   input  logic wr_bit,
   output logic flag,
   output logic armed
);

   logic clr_hit;
   logic flag_d;
   logic armed_d;

   // a clear needs a zero data bit and a previous read that saw one
   assign clr_hit = wr_stat & ~wr_bit & armed;
   // a set pulse beats a clear in the same cycle
   assign flag_d  = hw_set | (flag & ~clr_hit);

   always_comb begin
      armed_d = armed;
      if (wr_stat)      armed_d = 1'b0;
      else if (rd_stat) armed_d = flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         flag  <= flag_d;
         armed <= armed_d;
      end
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);                                          // R3
   AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !hw_set) |=> !flag);                             // R3
   AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && wr_stat && wr_bit) |=> flag);                     // R4
   AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !armed) |=> flag);                                // R5
   AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> !armed);                                       // R6
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && wr_stat && !wr_bit) |=> flag);                  // R7

endmodule

// File: rtl/evt_flag_enable.sv
module evt_flag_enable #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned EN_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [EN_W-1:0]   wdata,
   output logic [EN_W-1:0]   en
);

   initial begin : prm_chk
      if (EN_W > DATA_W) $error("enable width exceeds data width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (wr_en) en <= wdata;
   end

   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en));                                   // R2
   AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en == $past(wdata)));                           // R2

endmodule

// File: rtl/evt_flag_irq.sv
module evt_flag_irq #(
   parameter int unsigned N_SRC = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src,
   input  logic [N_SRC-1:0]  en,
   output logic              level,
   output logic              pulse
);

   logic level_q;

   assign level = |(src & en);
   assign pulse = level & ~level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);                                         // R9
   AST_LEVEL_HOLDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (level && !pulse) |-> level_q);                            // R9
   AST_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(level) |-> !pulse);                                  // R11

endmodule

// File: rtl/evt_flag_readmux.sv
module evt_flag_readmux
   import evt_flag_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAT_W = 6,
   parameter int unsigned EN_W   = 5,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel,
   input  logic              rd,
   input  logic [STAT_W-1:0] stat,
   input  logic [EN_W-1:0]   en,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (rd) begin
         unique case (sel)
            SEL_STAT: rd_val = DATA_W'(stat);
            SEL_EN:   rd_val = DATA_W'(en);
            default:  rd_val = '0;
         endcase
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_val;
         end
      end else begin : g_rd_comb
         assign rdata = rd_val;
      end
   endgenerate

   generate
      if (STAT_W < DATA_W) begin : g_rsvd_chk
         AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[DATA_W-1:STAT_W] == '0);                       // R1
      end
   endgenerate

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
   import evt_flag_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned N_CMP     = DEF_N_CMP,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned EN_ADDR   = 1,
   parameter bit          RD_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_CMP-1:0]  evt_cmp,
   input  logic              evt_ovf,
   input  logic              evt_udf,
   output logic              irq_level,
   output logic              irq_pulse
);

   // derived geometry
   localparam int unsigned STAT_W = N_CMP + 2;  // compare flags, overflow, underflow
   localparam int unsigned EN_W   = N_CMP + 1;  // underflow has no enable
   localparam int unsigned OVF_B  = N_CMP;
   localparam int unsigned UDF_B  = N_CMP + 1;

   initial begin : prm_chk
      if (STAT_W > DATA_W)        $error("status field does not fit the data width");
      if (ADDR_W != DEF_ADDR_W)   $error("address width must match the package decoder");
      if (STAT_ADDR == EN_ADDR)   $error("register addresses collide");
      if (N_CMP == 0)             $error("at least one compare source is required");
   end

   reg_sel_e          sel;
   logic              rd_stat;
   logic              wr_stat;
   logic              wr_en;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] flags;
   logic [STAT_W-1:0] armed;
   logic [EN_W-1:0]   en;

   assign sel     = decode_sel(bus_addr, ADDR_W'(STAT_ADDR), ADDR_W'(EN_ADDR));
   assign rd_stat = bus_rd & (sel == SEL_STAT);
   assign wr_stat = bus_wr & (sel == SEL_STAT);
   assign wr_en   = bus_wr & (sel == SEL_EN);

   always_comb begin
      set_vec             = '0;
      set_vec[N_CMP-1:0]  = evt_cmp;
      set_vec[OVF_B]      = evt_ovf;
      set_vec[UDF_B]      = evt_udf;
   end

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_cell
         evt_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (set_vec[b]),
            .rd_stat (rd_stat),
            .wr_stat (wr_stat),
            .wr_bit  (bus_wdata[b]),
            .flag    (flags[b]),
            .armed   (armed[b])
         );
      end
   endgenerate

   evt_flag_enable #(
      .DATA_W (DATA_W),
      .EN_W   (EN_W)
   ) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (bus_wdata[EN_W-1:0]),
      .en    (en)
   );

   evt_flag_irq #(
      .N_SRC (EN_W)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (flags[EN_W-1:0]),
      .en    (en),
      .level (irq_level),
      .pulse (irq_pulse)
   );

   evt_flag_readmux #(
      .DATA_W (DATA_W),
      .STAT_W (STAT_W),
      .EN_W   (EN_W),
      .RD_REG (RD_REG)
   ) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .rd    (bus_rd),
      .stat  (flags),
      .en    (en),
      .rdata (bus_rdata)
   );

   AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !wr_stat) |=> (armed == $past(flags)));        // R6
   AST_UDF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level |-> |(flags[EN_W-1:0] & en)));                  // R8
   AST_ARMED_ONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE && bus_wr) |=> $stable(en));              // R2

endmodule

// File: tb/evt_flag_bank_test.sv
`timescale 1ns/1ps
module evt_flag_bank_test;

   localparam int NV = 21;
   localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

   // {op, addr, data, set[5:0]={udf,ovf,D,C,B,A}, exp_rdata, exp_level, exp_pulse}
   localparam logic [27:0] VEC [NV] = '{
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_IDLE, 2'd0, 8'h00, 6'h01, 8'h00, 1'b0, 1'b0},
      {OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h01, 1'b0, 1'b0},
      {OP_IDLE, 2'd0, 8'h00, 6'h02, 8'h00, 1'b0, 1'b0},
      {OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h02, 1'b0, 1'b0},
      {OP_WR,   2'd1, 8'h02, 6'h00, 8'h00, 1'b1, 1'b1},
      {OP_RD,   2'd1, 8'h00, 6'h00, 8'h02, 1'b1, 1'b0},
      {OP_WR,   2'd0, 8'hFF, 6'h00, 8'h00, 1'b1, 1'b0},
      {OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b1, 1'b0},
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h02, 1'b1, 1'b0},
      {OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_IDLE, 2'd0, 8'h00, 6'h20, 8'h00, 1'b0, 1'b0},
      {OP_WR,   2'd1, 8'hFF, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_RD,   2'd1, 8'h00, 6'h00, 8'h1F, 1'b0, 1'b0},
      {OP_IDLE, 2'd0, 8'h00, 6'h10, 8'h00, 1'b1, 1'b1},
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h30, 1'b1, 1'b0},
      {OP_WR,   2'd0, 8'hEF, 6'h00, 8'h00, 1'b0, 1'b0},
      {OP_RD,   2'd0, 8'h00, 6'h00, 8'h20, 1'b0, 1'b0},
      {OP_RD,   2'd2, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:       return "R10";
         1, 4, 13: return "R3";
         2, 5:    return "R5";
         3, 17, 20: return "R1";
         6, 10, 12, 18: return "R6";
         7, 16:   return "R9";
         8, 15:   return "R2";
         9, 11, 19: return "R4";
         14:      return "R8";
         default: return "R1";
      endcase
   endfunction

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] evt_cmp = '0;
   logic       evt_ovf = 1'b0;
   logic       evt_udf = 1'b0;
   logic       irq_level;
   logic       irq_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   evt_flag_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_cmp   (evt_cmp),
      .evt_ovf   (evt_ovf),
      .evt_udf   (evt_udf),
      .irq_level (irq_level),
      .irq_pulse (irq_pulse)
   );

   task automatic check(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   // one bus cycle: drive at the falling edge, read data before the rising edge,
   // level and pulse just after it
   task automatic step(input logic [1:0] op, input logic [1:0] addr,
                       input logic [7:0] data, input logic [5:0] set,
                       input logic [7:0] exp_rd, input logic exp_lvl,
                       input logic exp_pls, input string tag);
      @(negedge clk);
      bus_addr  = addr;
      bus_rd    = (op == OP_RD);
      bus_wr    = (op == OP_WR);
      bus_wdata = data;
      evt_cmp   = set[3:0];
      evt_ovf   = set[4];
      evt_udf   = set[5];
      #1;
      if (op == OP_RD) check(tag, "rdata", bus_rdata, exp_rd);
      @(posedge clk);
      #1;
      check(tag, "irq_level", {7'd0, irq_level}, {7'd0, exp_lvl});
      check(tag, "irq_pulse", {7'd0, irq_pulse}, {7'd0, exp_pls});
      @(negedge clk);
      bus_rd  = 1'b0;
      bus_wr  = 1'b0;
      evt_cmp = '0;
      evt_ovf = 1'b0;
      evt_udf = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state through the ports
      check("R10", "irq_level after reset", {7'd0, irq_level}, 8'h00);
      check("R10", "irq_pulse after reset", {7'd0, irq_pulse}, 8'h00);
      step(OP_RD, 2'd1, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R10");

      // table walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][27:26], VEC[i][25:24], VEC[i][23:16], VEC[i][15:10],
              VEC[i][9:2], VEC[i][1], VEC[i][0], vec_tag(i));
      end

      // R7: set pulse in the same cycle as an armed clear (flags now 0x20, enables 0x1F)
      step(OP_IDLE, 2'd0, 8'h00, 6'h01, 8'h00, 1'b1, 1'b1, "R3");
      step(OP_RD,   2'd0, 8'h00, 6'h00, 8'h21, 1'b1, 1'b0, "R7");
      step(OP_WR,   2'd0, 8'h00, 6'h01, 8'h00, 1'b1, 1'b0, "R7");
      step(OP_RD,   2'd0, 8'h00, 6'h00, 8'h01, 1'b1, 1'b0, "R7");

      // R11: clear a masked flag together with an enabled one in one write
      step(OP_WR,   2'd1, 8'h01, 6'h00, 8'h00, 1'b1, 1'b0, "R2");
      step(OP_IDLE, 2'd0, 8'h00, 6'h02, 8'h00, 1'b1, 1'b0, "R11");
      step(OP_RD,   2'd0, 8'h00, 6'h00, 8'h03, 1'b1, 1'b0, "R11");
      step(OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R11");
      step(OP_RD,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R11");
      step(OP_IDLE, 2'd0, 8'h00, 6'h02, 8'h00, 1'b0, 1'b0, "R8");

      // R10: reset in the middle of activity
      step(OP_IDLE, 2'd0, 8'h00, 6'h01, 8'h00, 1'b1, 1'b1, "R9");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", "irq_level in reset", {7'd0, irq_level}, 8'h00);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      step(OP_RD, 2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R10");
      step(OP_RD, 2'd1, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R10");
      // arm latches were cleared too: a write of zero after reset clears nothing new
      step(OP_IDLE, 2'd0, 8'h00, 6'h04, 8'h00, 1'b0, 1'b0, "R3");
      step(OP_WR,   2'd0, 8'h00, 6'h00, 8'h00, 1'b0, 1'b0, "R5");
      step(OP_RD,   2'd0, 8'h00, 6'h00, 8'h04, 1'b0, 1'b0, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule